// File: doc/BRIEF.md
# Dual-Path Level Interrupt Controller

This block gathers up to 32 level-sensitive interrupt sources and presents them to a processor as two independent requests: a normal request and a fast request. Each request has its own enable mask. Software changes a mask only through a pair of write-one-to-set and write-one-to-clear locations, so it never needs a read-modify-write sequence. A software trigger register, also changed through a set/clear pair, lets software raise any valid source without hardware.

A build-time valid mask marks which of the 32 positions are wired to real sources. Positions outside the mask never pend, never store an enable or software-trigger bit, and always read as zero. Software services a request by reading the masked status of its path, handling the lowest set bit first, and reading again until the value is zero. Because sources are level-sensitive, a bit stays pending for as long as its source is held and enabled.

Top module: `lvl_intc`

## Requirements
- R1: After reset both enable masks and the software trigger register are zero, and both request outputs are low.
- R2: A write to 0x08 (normal path) or 0x28 (fast path) sets the enable bits whose data bit is 1 and leaves all other enable bits unchanged.
- R3: A write to 0x0C (normal path) or 0x2C (fast path) clears the enable bits whose data bit is 1 and leaves all other enable bits unchanged.
- R4: A write to 0x10 sets, and a write to 0x14 clears, the software trigger bits whose data bit is 1. Other bits keep their value.
- R5: Raw status, readable at 0x04 and at 0x24, equals (source inputs OR software trigger) AND valid mask, with bit n matching source n.
- R6: Masked status at 0x00 equals raw status AND the normal enable mask. Masked status at 0x20 equals raw status AND the fast enable mask. The two paths do not affect each other.
- R7: A read of 0x08 or 0x0C returns the normal enable mask. A read of 0x28 or 0x2C returns the fast enable mask. A read of 0x10 or 0x14 returns the software trigger register.
- R8: Each request output is high exactly one clock after its path's masked status is non-zero.
- R9: Any other address, including addresses whose low two bits are not zero, reads as zero, and a write to it changes no state.
- R10: Bit positions outside the valid mask read as zero in every register and cannot be set.
- R11: Sources are not latched. A pending bit clears as soon as its source input and trigger bit are both low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 32 | Level-sensitive source inputs, bit n is source n |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Registered normal interrupt request |
| fiq_o | output | 1 | Registered fast interrupt request |

## Verification
The assertions assume that the bus makes at most one write per cycle. With a single write port, a set and a clear of the same register can never arrive together, so the set and clear properties exclude that overlap instead of ranking it. The stimulus holds bus_we for exactly one clock per write and leaves it low during read sweeps. It changes source levels only at the falling edge, together with the write, so every property sees stable inputs at the rising edge.

// File: rtl/lvl_intc_pkg.sv
// Package: register offsets and widths shared by the controller.
// Assumes byte addressing with 32-bit registers on word boundaries.
package lvl_intc_pkg;
    localparam int unsigned REG_AW = 6;
    localparam int unsigned NSRC   = 32;

    typedef logic [REG_AW-1:0] reg_addr_t;

    // Offsets are kept fixed because driver software decodes them.
    localparam reg_addr_t OFS_N_MASKED = 6'h00;
    localparam reg_addr_t OFS_N_RAW    = 6'h04;
    localparam reg_addr_t OFS_N_ENSET  = 6'h08;
    localparam reg_addr_t OFS_N_ENCLR  = 6'h0C;
    localparam reg_addr_t OFS_SW_SET   = 6'h10;
    localparam reg_addr_t OFS_SW_CLR   = 6'h14;
    localparam reg_addr_t OFS_F_MASKED = 6'h20;
    localparam reg_addr_t OFS_F_RAW    = 6'h24;
    localparam reg_addr_t OFS_F_ENSET  = 6'h28;
    localparam reg_addr_t OFS_F_ENCLR  = 6'h2C;

    // Index of each set/clear register in the register bank.
    localparam int unsigned BANK_N  = 0;
    localparam int unsigned BANK_F  = 1;
    localparam int unsigned BANK_SW = 2;
    localparam int unsigned NBANK   = 3;
endpackage

// File: rtl/lvl_intc_sc_reg.sv
// Module: a write-one-to-set / write-one-to-clear register.
// Only positions marked in VALID can hold a one. A clear wins over a set
// on the same bit. Assumes set_i and clr_i are one-cycle write pulses.
module lvl_intc_sc_reg #(
    parameter int unsigned W     = 32,
    parameter logic [W-1:0] VALID = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q_r;

    // Update the stored bits from the set and clear pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_r <= '0;
        end else begin
            q_r <= ((q_r | set_i) & ~clr_i) & VALID;
        end
    end

    assign q_o = q_r;

    // A set without a clear turns on every valid bit that was written.
    assert_set_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0 && clr_i == '0) |=>
        ((q_o & ($past(set_i) & VALID)) == ($past(set_i) & VALID)));

    // A clear turns off every bit that was written.
    assert_clr_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i != '0) |=> ((q_o & $past(clr_i)) == '0));

    // With no write the register keeps its value.
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i == '0 && clr_i == '0) |=> $stable(q_o));
endmodule

// File: rtl/lvl_intc_path.sv
// Module: one request path (normal or fast). Masks the raw status with the
// path enable and registers the OR of the result as the request line.
// Assumes raw_i is already limited to valid positions.
module lvl_intc_path #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    input  logic [W-1:0] en_i,
    output logic [W-1:0] masked_o,
    output logic         req_o
);
    logic req_r;

    assign masked_o = raw_i & en_i;

    // Register the aggregate request for one cycle of latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_r <= 1'b0;
        end else begin
            req_r <= |masked_o;
        end
    end

    assign req_o = req_r;

    // The request follows the masked status one cycle later.
    assert_req_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (req_o == ($past(masked_o) != '0)));

    // A masked bit needs both a pending source and an enable.
    assert_masked_subset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((masked_o & ~raw_i) == '0) && ((masked_o & ~en_i) == '0));
endmodule

// File: rtl/lvl_intc.sv
// Module: top of the dual-path level interrupt controller. Decodes the
// register bus, holds the two enable masks and the software trigger, and
// drives the normal and fast request lines. Assumes one write per cycle
// and byte addresses; reads are combinational from bus_addr.
module lvl_intc
    import lvl_intc_pkg::*;
#(
    parameter logic [31:0] VALID_MASK = 32'h0FFF_FFF7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] src_i,
    input  logic        bus_we,
    input  logic [5:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq_o,
    output logic        fiq_o
);
    localparam int unsigned W = NSRC;

    logic [W-1:0] set_v  [NBANK];
    logic [W-1:0] clr_v  [NBANK];
    logic [W-1:0] bank_q [NBANK];
    logic [W-1:0] raw;
    logic [W-1:0] masked [2];
    logic         req    [2];

    // Turn a bus write into set and clear pulses for each register.
    always_comb begin
        for (int b = 0; b < int'(NBANK); b++) begin
            set_v[b] = '0;
            clr_v[b] = '0;
        end
        if (bus_we) begin
            case (bus_addr)
                OFS_N_ENSET: set_v[BANK_N]  = bus_wdata;
                OFS_N_ENCLR: clr_v[BANK_N]  = bus_wdata;
                OFS_F_ENSET: set_v[BANK_F]  = bus_wdata;
                OFS_F_ENCLR: clr_v[BANK_F]  = bus_wdata;
                OFS_SW_SET:  set_v[BANK_SW] = bus_wdata;
                OFS_SW_CLR:  clr_v[BANK_SW] = bus_wdata;
                default: ;
            endcase
        end
    end

    // One set/clear register per enable mask and for the software trigger.
    for (genvar b = 0; b < int'(NBANK); b++) begin : g_bank
        lvl_intc_sc_reg #(.W(W), .VALID(VALID_MASK)) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_v[b]),
            .clr_i (clr_v[b]),
            .q_o   (bank_q[b])
        );
    end

    // Raw status is shared by both paths.
    assign raw = (src_i | bank_q[BANK_SW]) & VALID_MASK;

    // One masking and request stage per output path.
    for (genvar p = 0; p < 2; p++) begin : g_path
        lvl_intc_path #(.W(W)) u_path (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw_i    (raw),
            .en_i     (bank_q[p]),
            .masked_o (masked[p]),
            .req_o    (req[p])
        );
    end

    assign irq_o = req[BANK_N];
    assign fiq_o = req[BANK_F];

    // Select the read data for the addressed register.
    always_comb begin
        case (bus_addr)
            OFS_N_MASKED:             bus_rdata = masked[BANK_N];
            OFS_N_RAW, OFS_F_RAW:     bus_rdata = raw;
            OFS_N_ENSET, OFS_N_ENCLR: bus_rdata = bank_q[BANK_N];
            OFS_SW_SET, OFS_SW_CLR:   bus_rdata = bank_q[BANK_SW];
            OFS_F_MASKED:             bus_rdata = masked[BANK_F];
            OFS_F_ENSET, OFS_F_ENCLR: bus_rdata = bank_q[BANK_F];
            default:                  bus_rdata = '0;
        endcase
    end

    // Nothing outside the valid mask ever reaches the read bus.
    assert_invalid_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & ~VALID_MASK) == '0);

    // An address with non-zero low bits reads as zero.
    assert_misaligned_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[1:0] != 2'b00) |-> (bus_rdata == '0));
endmodule

// File: tb/lvl_intc_bench.sv
// Bench: random writes and source changes mixed with directed corner cases.
// A bench-side model of the register state gives every expected value.
module lvl_intc_bench;
    localparam logic [31:0] VM = 32'h0FFF_FFF7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_i = '0;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, fiq_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [31:0] m_en_n = '0, m_en_f = '0, m_sw = '0;

    always #5 clk = ~clk;

    lvl_intc #(.VALID_MASK(VM)) u_lvl_intc (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    function automatic logic [31:0] m_raw();
        return (src_i | m_sw) & VM;
    endfunction

    // Expected read data from the model, by address.
    function automatic logic [31:0] exp_read(input logic [5:0] a);
        case (a)
            6'h00: return m_raw() & m_en_n;
            6'h04, 6'h24: return m_raw();
            6'h08, 6'h0C: return m_en_n;
            6'h10, 6'h14: return m_sw;
            6'h20: return m_raw() & m_en_f;
            6'h28, 6'h2C: return m_en_f;
            default: return '0;
        endcase
    endfunction

    // Apply a write to the model.
    function automatic void m_write(input logic [5:0] a, input logic [31:0] d);
        case (a)
            6'h08: m_en_n = (m_en_n | d) & VM;
            6'h0C: m_en_n = m_en_n & ~d;
            6'h28: m_en_f = (m_en_f | d) & VM;
            6'h2C: m_en_f = m_en_f & ~d;
            6'h10: m_sw = (m_sw | d) & VM;
            6'h14: m_sw = m_sw & ~d;
            default: ;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One write, issued at a falling edge and applied at the next rising edge.
    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        m_write(a, d);
    endtask

    task automatic read_check(input string req, input logic [5:0] a);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp_read(a));
    endtask

    // Read every mapped address plus some unmapped ones.
    task automatic sweep(input string req);
        for (int i = 0; i < 16; i++) read_check(req, 6'(i * 4));
        read_check(req, 6'h09);
    endtask

    // Wait one clock with no write, then compare both request lines.
    task automatic req_check(input string req);
        @(negedge clk);
        check(req, {30'd0, fiq_o, irq_o},
              {30'd0, (m_raw() & m_en_f) != '0, (m_raw() & m_en_n) != '0});
    endtask

    initial begin
        int unsigned sd;
        sd = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", {30'd0, fiq_o, irq_o}, 32'd0);
        read_check("R1", 6'h08);
        read_check("R1", 6'h28);
        read_check("R1", 6'h10);

        // R2 and R10: setting all ones keeps only valid positions
        bus_write(6'h08, 32'hFFFF_FFFF);
        check("R2/R10", bus_rdata & 0, 0);
        read_check("R10", 6'h08);
        check("R10", exp_read(6'h08), VM);
        // R3: clear only written bits, the rest stay
        bus_write(6'h0C, 32'h0000_FF00);
        read_check("R3", 6'h0C);
        // R6: the fast path is unaffected by normal enables
        read_check("R6", 6'h28);
        // R4: software trigger set, then partial clear
        bus_write(6'h10, 32'h0000_0300);
        read_check("R4", 6'h14);
        read_check("R6", 6'h00);
        req_check("R8 sw trigger masked on normal path");
        bus_write(6'h14, 32'h0000_0200);
        read_check("R4", 6'h10);
        bus_write(6'h14, 32'h0000_0100);
        req_check("R8 no pending after clear");

        // R11: level source pends while high, clears when it drops
        bus_write(6'h28, 32'h0000_0001);
        @(negedge clk); src_i = 32'h0000_0001; m_write(6'h3F, 0);
        read_check("R11", 6'h20);
        read_check("R5", 6'h24);
        req_check("R8 fast path rises");
        src_i = '0;
        read_check("R11", 6'h20);
        req_check("R8 fast path falls");
        // R10: an invalid source never pends
        src_i = 32'h8000_0008;
        read_check("R10", 6'h04);
        req_check("R10");
        src_i = '0;
        // R9: unmapped and misaligned writes change nothing
        bus_write(6'h18, 32'hFFFF_FFFF);
        bus_write(6'h09, 32'hFFFF_FFFF);
        bus_write(6'h30, 32'hFFFF_FFFF);
        sweep("R9");

        // Random phase: R2 R3 R4 R5 R6 R7 R8 R9
        for (int it = 0; it < 400; it++) begin
            logic [5:0] a;
            a = 6'(($urandom % 16) * 4);
            if (($urandom % 8) == 0) a = a | 6'h1;
            @(negedge clk);
            src_i = $urandom & $urandom;
            bus_addr = a; bus_wdata = $urandom; bus_we = 1'b1;
            @(negedge clk);
            bus_we = 1'b0;
            m_write(a, bus_wdata);
            sweep("R5/R6/R7 random");
            req_check("R8 random");
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule